// File: doc/BRIEF.md
# JTAG Chain Scan Master

This block drives a JTAG scan chain from the system clock. It reads or writes the instruction register or the data register of one TAP that sits among other TAPs in a serial chain. A command gives the scan type, the payload length and a payload word, together with a start pulse. The block then generates TCK, TMS and TDI and samples TDO. When the scan completes, it returns the bits that the addressed TAP shifted out and raises a one-cycle done flag.

Every scan begins and ends in a chosen parking state, either Run-Test/Idle or Select-DR-Scan. The block adds the padding for the other TAPs in the chain, so the caller only deals with the addressed TAP. Four counts describe where that TAP sits. The leading counts give how many bits belong to TAPs between the target and TDO. The trailing counts give how many bits belong to TAPs between TDI and the target. There is one pair of counts for instruction scans and one pair for data scans. During an instruction scan the other TAPs receive all-ones (BYPASS). During a data scan each bypassed TAP receives one zero bit.

Top module: `jtag_chain_master`

## Requirements
- R1: After reset, tck_o is low, busy_o and done_o are low and rdata_o is zero.
- R2: While a scan runs, TCK has a period of 2*(tck_div_i+1) system clocks, with equal high and low halves. tck_div_i is taken at start. TCK stays low whenever busy_o is low.
- R3: TMS and TDI change only while TCK is low. They hold steady from each TCK rising edge until the next falling edge. TDO is sampled when TCK rises.
- R4: park_code_i equal to 7 selects Select-DR-Scan as the parking state, and any other code selects Run-Test/Idle (code 12). The entry TMS path depends on the parking state. From Run-Test/Idle it is 1,0,0 for a data scan and 1,1,0,0 for an instruction scan. From Select-DR-Scan it is 0,0 for a data scan and 1,0,0 for an instruction scan.
- R5: An instruction scan shifts ir_pre_i one-bits first, then the payload LSB first, then ir_post_i one-bits.
- R6: A data scan shifts dr_pre_i zero-bits first, then the payload LSB first, then dr_post_i zero-bits.
- R7: The last shifted bit goes out with TMS=1. It is followed by TMS 1 and then TMS 0 (Run-Test/Idle) or TMS 1 (Select-DR-Scan), so the chain ends in the parking state. A scan has exactly entry + pre + len + post + 2 TCK rising edges, where len is the payload bit count.
- R8: rdata_o drops the first pre TDO samples and keeps the next len samples at bits 0 upward. All bits above len are zero. The value is valid when done_o pulses and holds until the next accepted start.
- R9: busy_o rises in the cycle after an accepted start and falls in the cycle in which done_o pulses for one cycle.
- R10: cmd_start_i is ignored while busy_o is high. Changes to the command or configuration inputs during a scan do not affect it.
- R11: The payload bit count is cmd_len_i+1, so a scan carries between 1 and DATA_W payload bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tck_div_i | input | DIV_W | TCK half-period minus one, in system clocks |
| ir_pre_i | input | PAD_W | Instruction bits of TAPs between the target and TDO |
| ir_post_i | input | PAD_W | Instruction bits of TAPs between TDI and the target |
| dr_pre_i | input | PAD_W | Bypass bits between the target and TDO |
| dr_post_i | input | PAD_W | Bypass bits between TDI and the target |
| park_code_i | input | 4 | Parking state code (7 or 12) |
| cmd_ir_i | input | 1 | 1 for an instruction scan, 0 for a data scan |
| cmd_len_i | input | $clog2(DATA_W) | Payload bit count minus one |
| cmd_data_i | input | DATA_W | Payload, LSB shifted first |
| cmd_start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured TDO bits of the addressed TAP |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Serial data to the chain |
| tdo_i | input | 1 | Serial data from the chain |

## Verification
An error in the step counter or the phase register shows up as a wrong number of TCK rising edges, and the TAP model then ends outside the parking state. The bench sees this when done pulses. A wrong window offset moves bypass bits into rdata_o and pushes the instruction or data bits into the wrong TAP, which the bench reads from the chain model in the same cycle. A faulty divider or a faulty latch of the configuration changes the measured TCK period or the edge count within the first scan after the fault.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ENTRY,
    PH_SHIFT,
    PH_EXIT
  } phase_e;

  localparam logic [3:0] PARK_SELDR = 4'd7;
endpackage

// File: rtl/jsm_tck_gen.sv
module jsm_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tck_q;
  logic             edge_now;

  assign edge_now = run_i && (cnt_q == '0);
  assign rise_o   = edge_now && !tck_q;
  assign fall_o   = edge_now && tck_q;
  assign tck_o    = tck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= div_i;
      tck_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= div_i;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  tck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tck_q);
endmodule

// File: rtl/jsm_seq.sv
module jsm_seq
  import jsm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAD_W  = 6,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ir_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PAD_W-1:0]  ir_pre_i,
  input  logic [PAD_W-1:0]  ir_post_i,
  input  logic [PAD_W-1:0]  dr_pre_i,
  input  logic [PAD_W-1:0]  dr_post_i,
  input  logic [3:0]        park_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              cap_clr_o,
  output logic              cap_wr_o,
  output logic [LEN_W-1:0]  cap_pos_o
);
  localparam int TOT_W = $clog2(2 * (2 ** PAD_W) + DATA_W + 4);

  phase_e            phase_q;
  logic [TOT_W-1:0]  idx_q;
  logic              ir_q, sel_q, done_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] data_q;
  logic [PAD_W-1:0]  pre_q, post_q;
  logic [DIV_W-1:0]  div_q;

  logic              start_ok, in_win;
  logic [TOT_W-1:0]  pre_w, win_hi, last_idx, entry_last;

  assign start_ok   = start_i && (phase_q == PH_IDLE);
  assign pre_w      = TOT_W'(pre_q);
  assign win_hi     = pre_w + TOT_W'(len_q);
  assign last_idx   = win_hi + TOT_W'(post_q);
  assign entry_last = ir_q ? (sel_q ? TOT_W'(2) : TOT_W'(3))
                           : (sel_q ? TOT_W'(1) : TOT_W'(2));
  assign in_win     = (idx_q >= pre_w) && (idx_q <= win_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      ir_q    <= 1'b0;
      sel_q   <= 1'b0;
      len_q   <= '0;
      data_q  <= '0;
      pre_q   <= '0;
      post_q  <= '0;
      div_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        phase_q <= PH_ENTRY;
        idx_q   <= '0;
        ir_q    <= ir_i;
        sel_q   <= (park_i == PARK_SELDR);
        len_q   <= len_i;
        data_q  <= data_i;
        pre_q   <= ir_i ? ir_pre_i : dr_pre_i;
        post_q  <= ir_i ? ir_post_i : dr_post_i;
        div_q   <= div_i;
      end else if (fall_i) begin
        unique case (phase_q)
          PH_ENTRY: begin
            if (idx_q == entry_last) begin
              phase_q <= PH_SHIFT;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          PH_SHIFT: begin
            if (idx_q == last_idx) begin
              phase_q <= PH_EXIT;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          PH_EXIT: begin
            if (idx_q[0]) begin
              phase_q <= PH_IDLE;
              idx_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // TMS/TDI decode from state that only moves on TCK falls
  always_comb begin
    tms_o = 1'b0;
    tdi_o = 1'b0;
    unique case (phase_q)
      PH_ENTRY: tms_o = (idx_q + 1'b1) < entry_last;
      PH_SHIFT: begin
        tms_o = (idx_q == last_idx);
        tdi_o = in_win ? data_q[cap_pos_o] : ir_q;
      end
      PH_EXIT:  tms_o = idx_q[0] ? sel_q : 1'b1;
      default:  ;
    endcase
  end

  assign cap_pos_o = LEN_W'(idx_q - pre_w);
  assign cap_wr_o  = rise_i && (phase_q == PH_SHIFT) && in_win;
  assign cap_clr_o = start_ok;
  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;
  assign div_o     = busy_o ? div_q : div_i;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R10
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(data_q) && $stable(len_q) && $stable(pre_q));
endmodule

// File: rtl/jsm_capture.sv
module jsm_capture #(
  parameter int DATA_W = 32,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [LEN_W-1:0]  pos_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (clr_i)  cap_q <= '0;
    else if (wr_i)   cap_q[pos_i] <= bit_i;
  end

  assign data_o = cap_q;
endmodule

// File: rtl/jtag_chain_master.sv
module jtag_chain_master #(
  parameter int DATA_W = 32,
  parameter int PAD_W  = 6,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  tck_div_i,
  input  logic [PAD_W-1:0]  ir_pre_i,
  input  logic [PAD_W-1:0]  ir_post_i,
  input  logic [PAD_W-1:0]  dr_pre_i,
  input  logic [PAD_W-1:0]  dr_post_i,
  input  logic [3:0]        park_code_i,
  input  logic              cmd_ir_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  logic             rise, fall, cap_clr, cap_wr;
  logic [LEN_W-1:0] cap_pos;
  logic [DIV_W-1:0] div_eff;

  jsm_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .div_i  (div_eff),
    .tck_o  (tck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  jsm_seq #(.DATA_W(DATA_W), .PAD_W(PAD_W), .DIV_W(DIV_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cmd_start_i),
    .ir_i      (cmd_ir_i),
    .len_i     (cmd_len_i),
    .data_i    (cmd_data_i),
    .ir_pre_i  (ir_pre_i),
    .ir_post_i (ir_post_i),
    .dr_pre_i  (dr_pre_i),
    .dr_post_i (dr_post_i),
    .park_i    (park_code_i),
    .div_i     (tck_div_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .tms_o     (tms_o),
    .tdi_o     (tdi_o),
    .div_o     (div_eff),
    .cap_clr_o (cap_clr),
    .cap_wr_o  (cap_wr),
    .cap_pos_o (cap_pos)
  );

  jsm_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cap_clr),
    .wr_i   (cap_wr),
    .pos_i  (cap_pos),
    .bit_i  (tdo_i),
    .data_o (rdata_o)
  );

  // R3
  tms_tdi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o && $past(tck_o) |-> $stable(tms_o) && $stable(tdi_o));
  // R2
  tck_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tck_o) |-> busy_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !tck_o);
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !$past(cmd_start_i) && !$rose(done_o) |-> $stable(rdata_o));
endmodule

// File: tb/jtag_chain_master_tb.sv
module jtag_chain_master_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int PAD_W  = 6;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 5;

  localparam logic [3:0] S_TLR = 4'd15, S_RTI = 4'd12, S_SDR = 4'd7, S_CDR = 4'd6,
                         S_SHD = 4'd2,  S_E1D = 4'd1,  S_PSD = 4'd3, S_E2D = 4'd0,
                         S_UPD = 4'd5,  S_SIR = 4'd4,  S_CIR = 4'd14, S_SHI = 4'd10,
                         S_E1I = 4'd9,  S_PSI = 4'd11, S_E2I = 4'd8, S_UPI = 4'd13;

  typedef struct packed {
    logic        ir;
    logic [4:0]  len;
    logic [31:0] data;
    logic [3:0]  park;
    logic [7:0]  div;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd4,  32'h0000_0002, 4'd12, 8'd1},
    '{1'b0, 5'd31, 32'hDEAD_BEEF, 4'd12, 8'd0},
    '{1'b0, 5'd7,  32'h0000_005A, 4'd7,  8'd2},
    '{1'b1, 5'd4,  32'h0000_000C, 4'd7,  8'd0},
    '{1'b0, 5'd15, 32'h0000_C33C, 4'd12, 8'd3},
    '{1'b1, 5'd4,  32'h0000_0002, 4'd12, 8'd0}
  };

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0]  tck_div = '0;
  logic [PAD_W-1:0]  ir_pre = 6'd6, ir_post = 6'd4, dr_pre = 6'd1, dr_post = 6'd1;
  logic [3:0]        park = 4'd12;
  logic              cmd_ir = 1'b0, cmd_start = 1'b0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic              busy, done, tck, tms, tdi;
  logic [DATA_W-1:0] rdata;
  logic              tdo = 1'b0;

  int tests = 0, fails = 0;

  jtag_chain_master #(.DATA_W(DATA_W), .PAD_W(PAD_W), .DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tck_div_i(tck_div),
    .ir_pre_i(ir_pre), .ir_post_i(ir_post), .dr_pre_i(dr_pre), .dr_post_i(dr_post),
    .park_code_i(park), .cmd_ir_i(cmd_ir), .cmd_len_i(cmd_len), .cmd_data_i(cmd_data),
    .cmd_start_i(cmd_start), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo)
  );

  always #(CLK_P/2) clk = ~clk;

  // Chain model: TDI -> tap0 (IR 4) -> tap1 target (IR 5) -> tap2 (IR 6) -> TDO
  logic [3:0]  tst = S_RTI;
  logic [14:0] ir_sh = '0;
  logic [3:0]  ir0 = 4'hF;
  logic [4:0]  ir1 = 5'h02;
  logic [5:0]  ir2 = 6'h3F;
  logic        b0 = 1'b0, b1 = 1'b0, b2 = 1'b0;
  logic [31:0] tgt_sh = '0, tgt_reg = 32'h1234_5678;
  int          tgt_len = 32;
  int          n_rise = 0;
  time         t1 = 0, t2 = 0;
  logic        tms_r = 1'b0, tdi_r = 1'b0;
  int          hold_err = 0;

  function automatic logic [3:0] nxt(input logic [3:0] s, input logic m);
    case (s)
      S_TLR: return m ? S_TLR : S_RTI;
      S_RTI: return m ? S_SDR : S_RTI;
      S_SDR: return m ? S_SIR : S_CDR;
      S_CDR: return m ? S_E1D : S_SHD;
      S_SHD: return m ? S_E1D : S_SHD;
      S_E1D: return m ? S_UPD : S_PSD;
      S_PSD: return m ? S_E2D : S_PSD;
      S_E2D: return m ? S_UPD : S_SHD;
      S_UPD: return m ? S_SDR : S_RTI;
      S_SIR: return m ? S_TLR : S_CIR;
      S_CIR: return m ? S_E1I : S_SHI;
      S_SHI: return m ? S_E1I : S_SHI;
      S_E1I: return m ? S_UPI : S_PSI;
      S_PSI: return m ? S_E2I : S_PSI;
      S_E2I: return m ? S_UPI : S_SHI;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic logic [31:0] mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  wire tgt_byp = (ir1 == 5'h1F);

  always @(posedge tck) begin
    if (n_rise == 0) t1 = $time;
    if (n_rise == 1) t2 = $time;
    n_rise = n_rise + 1;
    tms_r <= tms;
    tdi_r <= tdi;
    case (tst)
      S_CIR: ir_sh <= {4'b0001, 5'b00001, 6'b000001};
      S_SHI: ir_sh <= {tdi, ir_sh[14:1]};
      S_UPI: {ir0, ir1, ir2} <= ir_sh;
      S_CDR: begin
        b0 <= 1'b0; b1 <= 1'b0; b2 <= 1'b0;
        tgt_sh <= tgt_reg & mask(tgt_len);
      end
      S_SHD: begin
        b0 <= tdi;
        if (tgt_byp) begin
          b1 <= b0;
          b2 <= b1;
        end else begin
          tgt_sh <= (tgt_sh >> 1) | ({31'b0, b0} << (tgt_len - 1));
          b2 <= tgt_sh[0];
        end
      end
      S_UPD: if (!tgt_byp) tgt_reg <= tgt_sh & mask(tgt_len);
      default: ;
    endcase
    tst <= nxt(tst, tms);
  end

  always @(negedge tck) begin
    if (tst == S_SHI) tdo <= ir_sh[0];
    else if (tst == S_SHD) tdo <= b2;
  end

  always @(negedge clk) begin
    if (tck && (tms !== tms_r || tdi !== tdi_r)) hold_err = hold_err + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic ir, input logic [4:0] len, input logic [31:0] data,
                          input logic [3:0] pk, input logic [7:0] dv);
    @(negedge clk);
    cmd_ir = ir; cmd_len = len; cmd_data = data; park = pk; tck_div = dv;
    n_rise = 0; t1 = 0; t2 = 0;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done();
    int c;
    c = 0;
    while (!done && c < 20000) begin
      @(negedge clk);
      c++;
    end
    if (c >= 20000) chk("R9 done timeout", 64'd0, 64'd1);
  endtask

  function automatic int entry_n(input logic ir, input logic [3:0] pk);
    int e;
    e = ir ? 4 : 3;
    if (pk == 4'd7) e--;
    return e;
  endfunction

  initial begin
    #(CLK_P * 190000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] prev, m;
    int exp_e, n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tck", {63'b0, tck}, 64'd0);
    chk("R1 busy/done", {62'b0, busy, done}, 64'd0);
    chk("R1 rdata", {32'b0, rdata}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      tst = (v.park == 4'd7) ? S_SDR : S_RTI;
      hold_err = 0;
      if (!v.ir) tgt_len = int'(v.len) + 1;
      prev = tgt_reg;
      m = mask(int'(v.len) + 1);
      n = v.ir ? (6 + 4) : (1 + 1);
      exp_e = entry_n(v.ir, v.park) + n + int'(v.len) + 1 + 2;
      start_op(v.ir, v.len, v.data, v.park, v.div);
      chk("R9 busy after start", {63'b0, busy}, 64'd1);
      wait_done();
      chk("R9 busy low at done", {63'b0, busy}, 64'd0);
      chk("R8 rdata", {32'b0, rdata}, v.ir ? 64'd1 : {32'b0, prev & m});
      chk(v.park == 4'd7 ? "R4 parked SelDR" : "R7 parked RTI", {60'b0, tst},
          {60'b0, (v.park == 4'd7) ? S_SDR : S_RTI});
      chk("R7 edge count", 64'(n_rise), 64'(exp_e));
      chk("R2 tck period", 64'(t2 - t1), 64'(2 * (int'(v.div) + 1) * CLK_P));
      chk("R3 tms/tdi hold", 64'(hold_err), 64'd0);
      if (v.ir) chk("R5 ir contents", {49'b0, ir0, ir1, ir2}, {49'b0, 4'hF, v.data[4:0], 6'h3F});
      else begin
        chk("R6 dr payload", {32'b0, tgt_reg}, {32'b0, v.data & m});
        chk("R6 post pad zero", {63'b0, b0}, 64'd0);
      end
    end

    // R10: start ignored while busy, config changes mid-scan ignored
    tst = S_RTI;
    tgt_len = 8;
    prev = tgt_reg;
    start_op(1'b0, 5'd7, 32'h3C, 4'd12, 8'd1);
    repeat (5) @(negedge clk);
    cmd_ir = 1'b1; cmd_data = 32'hFF; dr_pre = 6'd5; tck_div = 8'd4; park = 4'd7;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_done();
    chk("R10 payload kept", {32'b0, tgt_reg}, 64'h3C);
    chk("R10 edges kept", 64'(n_rise), 64'(3 + 1 + 8 + 1 + 2));
    chk("R10 rdata", {32'b0, rdata}, {32'b0, prev & mask(8)});
    dr_pre = 6'd1; park = 4'd12;
    n = n_rise;
    repeat (30) @(negedge clk);
    chk("R10 no late start", {63'b0, busy}, 64'd0);
    chk("R2 tck idle", 64'(n_rise), 64'(n));
    chk("R8 rdata holds", {32'b0, rdata}, {32'b0, prev & mask(8)});

    // R11: minimum length, target in bypass
    start_op(1'b1, 5'd4, 32'h1F, 4'd12, 8'd0);
    wait_done();
    chk("R5 target bypass ir", {59'b0, ir1}, 64'h1F);
    prev = tgt_reg;
    start_op(1'b0, 5'd0, 32'h1, 4'd12, 8'd0);
    wait_done();
    chk("R11 one-bit rdata", {32'b0, rdata}, 64'd0);
    chk("R11 one-bit edges", 64'(n_rise), 64'(3 + 3 + 2));
    chk("R11 target untouched", {32'b0, tgt_reg}, {32'b0, prev});

    // R4: unlisted park code behaves as Run-Test/Idle
    start_op(1'b1, 5'd4, 32'h02, 4'd5, 8'd0);
    wait_done();
    chk("R4 code 5 parks RTI", {60'b0, tst}, {60'b0, S_RTI});
    chk("R4 code 5 edges", 64'(n_rise), 64'(4 + 15 + 2));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule